// File: doc/BRIEF.md
# DDR SDRAM Mode Register Decoder

This block watches the command bus of a DDR memory and picks out the mode-set command, which is the one cycle where chip select, row strobe, column strobe and write enable are all sampled low. The bank-address pair decides the target. Code 00 writes the base register, which holds burst length, burst ordering and read latency. Code 10 writes the extended register, which holds the part of the array kept during self refresh and the output drive strength. The decoded fields are held in registers and driven out as plain numbers, so the controller and datapath logic can use them directly.

Every write is checked before it is taken. A reserved field code, a set bit that must be zero, an unused bank code, or a command that arrives while the block is still busy from the previous write is rejected. A rejected write leaves both registers as they were and sets a sticky error flag. A successful write holds `busy` high for two cycles. A successful base write also puts the extended register back to its defaults. `cfg_valid` marks that the base register holds a real setting.

Top module: `mode_reg_decoder`

## Requirements
- R1: While reset is active and just after it, `busy`, `cfg_valid` and `cfg_error` are 0, `burst_len`, `interleave` and `cas_lat` are 0, `refresh_area` is 0 (full array) and `drive_str` is 1 (half strength).
- R2: A command is a mode set only when `cs_n`, `ras_n`, `cas_n` and `we_n` are all sampled low. Any other combination on these four inputs changes no output.
- R3: A mode set with `bank`=00 and legal fields writes the base register. `addr[2:0]` codes 001/010/011/100 give `burst_len` 2/4/8/16. `addr[3]` drives `interleave` (0 sequential, 1 interleaved). `addr[6:4]` codes 010/011 give `cas_lat` 2/3. The outputs show the new values from the clock edge that samples the command.
- R4: A mode set with `bank`=10 and legal fields writes the extended register. `addr[2:0]` codes 000/001/010 give `refresh_area` 0/1/2 (full, half, quarter). `addr[6:5]` is copied to `drive_str` (0 full, 1 half, 2 quarter, 3 eighth).
- R5: Every successful base write also sets `refresh_area` to 0 and `drive_str` to 1, whatever values the extended register held before.
- R6: After a successful write, `busy` is high for exactly two clock cycles. A mode set sampled while `busy` is high is rejected: no register changes and `cfg_error` is set.
- R7: A base write is rejected, with no register change and `cfg_error` set, if `addr[2:0]` is 000 or 101..111, if `addr[6:4]` is anything other than 010 or 011, or if any of `addr[12:7]` is 1.
- R8: An extended write is rejected, with no register change and `cfg_error` set, if `addr[2:0]` is 011..111 or if any of `addr[4:3]` or `addr[12:7]` is 1.
- R9: A mode set with `bank` 01 or 11 is rejected, with no register change and `cfg_error` set. It does not start `busy`.
- R10: `cfg_error` stays high after it is set, through any later successful writes, until reset.
- R11: `cfg_valid` goes high at the first successful base write and stays high until reset. Extended writes do not set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | 2 | Bank address; selects the target register during a mode set |
| addr | input | ADDR_W | Address bus carrying the register op-code |
| busy | output | 1 | High for two cycles after a successful write |
| cfg_valid | output | 1 | Base register has been written since reset |
| cfg_error | output | 1 | Sticky flag for a rejected mode set |
| burst_len | output | 5 | Burst length in beats (2, 4, 8 or 16) |
| interleave | output | 1 | 1 for interleaved burst order, 0 for sequential |
| cas_lat | output | 2 | Read latency in cycles (2 or 3) |
| refresh_area | output | 2 | Self-refresh extent: 0 full, 1 half, 2 quarter |
| drive_str | output | 2 | Drive strength: 0 full, 1 half, 2 quarter, 3 eighth |

## Verification
The hardest case to reach is a mode set that lands inside the two-cycle busy window. A command in that window must be rejected even when its fields are valid, and the window must not be extended by it. The stimulus reaches this case by issuing a legal write and then driving legal writes on the very next cycle and on the cycle after that, before a third one arrives once `busy` has dropped. Because the error flag is sticky, each rejection is also judged by the registers staying unchanged. A reset in the middle of the run then clears the flag so that the bank-code rejection can be seen setting it on its own.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    // Decoded base register contents
    typedef struct packed {
        logic [4:0] burst_len;
        logic       interleave;
        logic [1:0] cas_lat;
    } base_cfg_t;

    // Decoded extended register contents
    typedef struct packed {
        logic [1:0] area;
        logic [1:0] drive;
    } ext_cfg_t;

    // Register target carried on the bank pins during a mode set
    typedef enum logic [1:0] {
        SEL_BASE  = 2'b00,
        SEL_BAD_A = 2'b01,
        SEL_EXT   = 2'b10,
        SEL_BAD_B = 2'b11
    } reg_sel_e;

    localparam base_cfg_t BASE_RESET  = '{burst_len: 5'd0, interleave: 1'b0, cas_lat: 2'd0};
    localparam ext_cfg_t  EXT_DEFAULT = '{area: 2'd0, drive: 2'd1};

endpackage

// File: rtl/mrd_base_decode.sv
module mrd_base_decode
    import mrd_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    output base_cfg_t         cfg,
    output logic              ok
);

    localparam int ZERO_LO = 7;

    logic len_ok;
    logic lat_ok;
    logic pad_ok;

    always_comb begin
        cfg            = BASE_RESET;
        len_ok         = 1'b1;
        lat_ok         = 1'b1;
        cfg.interleave = addr[3];

        case (addr[2:0])
            3'b001:  cfg.burst_len = 5'd2;
            3'b010:  cfg.burst_len = 5'd4;
            3'b011:  cfg.burst_len = 5'd8;
            3'b100:  cfg.burst_len = 5'd16;
            default: len_ok        = 1'b0;
        endcase

        case (addr[6:4])
            3'b010:  cfg.cas_lat = 2'd2;
            3'b011:  cfg.cas_lat = 2'd3;
            default: lat_ok      = 1'b0;
        endcase

        pad_ok = (addr[ADDR_W-1:ZERO_LO] == '0);
        ok     = len_ok && lat_ok && pad_ok;
    end

endmodule

// File: rtl/mrd_ext_decode.sv
module mrd_ext_decode
    import mrd_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    output ext_cfg_t          cfg,
    output logic              ok
);

    localparam int ZERO_LO = 7;

    logic area_ok;
    logic pad_ok;

    always_comb begin
        cfg       = EXT_DEFAULT;
        area_ok   = 1'b1;
        cfg.drive = addr[6:5];

        case (addr[2:0])
            3'b000:  cfg.area = 2'd0;
            3'b001:  cfg.area = 2'd1;
            3'b010:  cfg.area = 2'd2;
            default: area_ok  = 1'b0;
        endcase

        pad_ok = (addr[4:3] == 2'b00) && (addr[ADDR_W-1:ZERO_LO] == '0);
        ok     = area_ok && pad_ok;
    end

endmodule

// File: rtl/mode_reg_decoder.sv
module mode_reg_decoder
    import mrd_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int BUSY_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [1:0]        bank,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              cfg_valid,
    output logic              cfg_error,
    output logic [4:0]        burst_len,
    output logic              interleave,
    output logic [1:0]        cas_lat,
    output logic [1:0]        refresh_area,
    output logic [1:0]        drive_str
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        base_cfg_t  base;
        ext_cfg_t   ext;
        logic       valid;
        logic       error;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t    st_d, st_q;
    base_cfg_t base_new;
    ext_cfg_t  ext_new;
    logic      base_ok;
    logic      ext_ok;
    logic      mode_set;
    logic      busy_now;

    mrd_base_decode #(.ADDR_W(ADDR_W)) u_base_dec (
        .addr (addr),
        .cfg  (base_new),
        .ok   (base_ok)
    );

    mrd_ext_decode #(.ADDR_W(ADDR_W)) u_ext_dec (
        .addr (addr),
        .cfg  (ext_new),
        .ok   (ext_ok)
    );

    assign mode_set = !cs_n && !ras_n && !cas_n && !we_n;
    assign busy_now = (st_q.cnt != '0);

    always_comb begin
        st_d = st_q;
        if (busy_now) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (mode_set) begin
            if (busy_now) begin
                st_d.error = 1'b1;
            end else begin
                case (reg_sel_e'(bank))
                    SEL_BASE: begin
                        if (base_ok) begin
                            st_d.base  = base_new;
                            st_d.ext   = EXT_DEFAULT;
                            st_d.valid = 1'b1;
                            st_d.cnt   = CNT_W'(BUSY_CYCLES);
                        end else begin
                            st_d.error = 1'b1;
                        end
                    end
                    SEL_EXT: begin
                        if (ext_ok) begin
                            st_d.ext = ext_new;
                            st_d.cnt = CNT_W'(BUSY_CYCLES);
                        end else begin
                            st_d.error = 1'b1;
                        end
                    end
                    default: st_d.error = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{base: BASE_RESET, ext: EXT_DEFAULT, valid: 1'b0,
                      error: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy         = busy_now;
    assign cfg_valid    = st_q.valid;
    assign cfg_error    = st_q.error;
    assign burst_len    = st_q.base.burst_len;
    assign interleave   = st_q.base.interleave;
    assign cas_lat      = st_q.base.cas_lat;
    assign refresh_area = st_q.ext.area;
    assign drive_str    = st_q.ext.drive;

endmodule

// File: rtl/mrd_checker.sv
module mrd_checker #(
    parameter int ADDR_W      = 13,
    parameter int BUSY_CYCLES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [1:0]        bank,
    input logic [ADDR_W-1:0] addr,
    input logic              busy,
    input logic              cfg_valid,
    input logic              cfg_error,
    input logic [4:0]        burst_len,
    input logic              interleave,
    input logic [1:0]        cas_lat,
    input logic [1:0]        refresh_area,
    input logic [1:0]        drive_str
);

    localparam int RUN_W = $clog2(BUSY_CYCLES + 2);

    logic          cmd_ms;
    logic [11:0]   fields;
    logic [RUN_W-1:0] run_q;

    assign cmd_ms = !cs_n && !ras_n && !cas_n && !we_n;
    assign fields = {burst_len, interleave, cas_lat, refresh_area, drive_str};

    // Count the busy cycles seen so far in the current busy run
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    assert_no_cmd_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ms |=> $stable(fields) && $stable(cfg_valid));

    assert_busy_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ms && busy |=> cfg_error && $stable(fields));

    assert_busy_run_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q < RUN_W'(BUSY_CYCLES));

    assert_busy_run_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(run_q) == RUN_W'(BUSY_CYCLES - 1));

    assert_bad_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ms && !busy && bank[0] |=> cfg_error && $stable(fields) && !busy);

    assert_error_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |=> cfg_error);

    assert_valid_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> cfg_valid);

    assert_valid_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> $onehot(burst_len) && !burst_len[0] && cas_lat[1]);

    assert_change_starts_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drive_str) || !$stable(refresh_area) |-> busy);

endmodule

bind mode_reg_decoder mrd_checker #(
    .ADDR_W      (ADDR_W),
    .BUSY_CYCLES (BUSY_CYCLES)
) u_mrd_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .bank         (bank),
    .addr         (addr),
    .busy         (busy),
    .cfg_valid    (cfg_valid),
    .cfg_error    (cfg_error),
    .burst_len    (burst_len),
    .interleave   (interleave),
    .cas_lat      (cas_lat),
    .refresh_area (refresh_area),
    .drive_str    (drive_str)
);

// File: tb/mode_reg_decoder_bench.sv
module mode_reg_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  bank = 2'b00;
    logic [12:0] addr = '0;
    logic        busy, cfg_valid, cfg_error, interleave;
    logic [4:0]  burst_len;
    logic [1:0]  cas_lat, refresh_area, drive_str;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles   = 0;
    string cur_req  = "R1";

    // Reference model state
    int m_bl = 0, m_il = 0, m_cl = 0, m_area = 0, m_drive = 1;
    int m_valid = 0, m_err = 0, m_busy = 0;

    always #10 clk = ~clk;

    mode_reg_decoder u_mode_reg_decoder (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .bank(bank), .addr(addr), .busy(busy),
        .cfg_valid(cfg_valid), .cfg_error(cfg_error), .burst_len(burst_len),
        .interleave(interleave), .cas_lat(cas_lat),
        .refresh_area(refresh_area), .drive_str(drive_str)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference, updated on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_bl = 0; m_il = 0; m_cl = 0; m_area = 0; m_drive = 1;
            m_valid = 0; m_err = 0; m_busy = 0;
        end else begin
            int  bl, cl, ar;
            bit  was_busy;
            was_busy = (m_busy > 0);
            if (m_busy > 0) m_busy--;
            if (!cs_n && !ras_n && !cas_n && !we_n) begin
                if (was_busy) m_err = 1;
                else if (bank == 2'b00) begin
                    case (addr[2:0])
                        3'd1: bl = 2;  3'd2: bl = 4;
                        3'd3: bl = 8;  3'd4: bl = 16;
                        default: bl = -1;
                    endcase
                    cl = (addr[6:4] == 3'd2) ? 2 : (addr[6:4] == 3'd3) ? 3 : -1;
                    if (bl > 0 && cl > 0 && addr[12:7] == 0) begin
                        m_bl = bl; m_il = addr[3]; m_cl = cl; m_valid = 1;
                        m_area = 0; m_drive = 1; m_busy = 2;
                    end else m_err = 1;
                end else if (bank == 2'b10) begin
                    ar = (addr[2:0] < 3) ? int'(addr[2:0]) : -1;
                    if (ar >= 0 && addr[4:3] == 0 && addr[12:7] == 0) begin
                        m_area = ar; m_drive = addr[6:5]; m_busy = 2;
                    end else m_err = 1;
                end else m_err = 1;
            end
        end
    end

    // Compare every cycle, half a period after the rising edge
    always @(negedge clk) begin
        check({cur_req, " busy"},  int'(busy), (m_busy > 0) ? 1 : 0);
        check({cur_req, " valid"}, int'(cfg_valid), m_valid);
        check({cur_req, " error"}, int'(cfg_error), m_err);
        check({cur_req, " fields"},
              int'({burst_len, interleave, cas_lat, refresh_area, drive_str}),
              (m_bl << 7) | (m_il << 6) | (m_cl << 4) | (m_area << 2) | m_drive);
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic drive(logic [3:0] c, logic [1:0] b, logic [12:0] a);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = c;
        bank = b;
        addr = a;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(4'b1111, 2'b00, '0);
    endtask

    task automatic mrs(logic [1:0] b, logic [12:0] a);
        drive(4'b0000, b, a);
        idle(4);
    endtask

    initial begin
        rst_n = 1'b0;
        idle(3);
        check("R1 drive default", int'(drive_str), 1);
        check("R1 valid low", int'(cfg_valid), 0);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R11";
        mrs(2'b10, 13'h041);                 // ext: half area, quarter drive
        check("R11 ext write leaves valid low", int'(cfg_valid), 0);
        check("R4 drive quarter", int'(drive_str), 2);

        cur_req = "R2";
        drive(4'b0011, 2'b00, 13'h033); idle(1);   // row open
        drive(4'b1000, 2'b00, 13'h033); idle(1);   // deselected
        drive(4'b0001, 2'b00, 13'h033); idle(2);   // refresh
        check("R2 no base write", int'(burst_len), 0);

        cur_req = "R3";
        mrs(2'b00, 13'h033);
        check("R3 len 8", int'(burst_len), 8);
        check("R3 latency 3", int'(cas_lat), 3);
        check("R5 area reset", int'(refresh_area), 0);
        check("R5 drive reset", int'(drive_str), 1);
        mrs(2'b00, 13'h02C);
        check("R3 len 16 interleave", int'({burst_len, interleave}), (16 << 1) | 1);
        mrs(2'b00, 13'h021);
        mrs(2'b00, 13'h03A);
        check("R3 len 4 lat 3", int'({burst_len, cas_lat}), (4 << 2) | 3);

        cur_req = "R4";
        mrs(2'b10, 13'h062);
        check("R4 area quarter", int'(refresh_area), 2);
        check("R4 drive eighth", int'(drive_str), 3);
        mrs(2'b10, 13'h001);

        cur_req = "R5";
        mrs(2'b00, 13'h023);
        check("R5 drive back to half", int'(drive_str), 1);

        cur_req = "R7";
        mrs(2'b00, 13'h020);                 // length code 000
        check("R7 error set", int'(cfg_error), 1);
        mrs(2'b00, 13'h072);                 // latency code 111
        mrs(2'b00, 13'h0A3);                 // bit 7 set
        mrs(2'b00, 13'h1033);                // bit 12 set

        cur_req = "R8";
        mrs(2'b10, 13'h003);                 // area code 011
        mrs(2'b10, 13'h008);                 // bit 3 set
        mrs(2'b10, 13'h110);                 // bits 8 and 4 set

        cur_req = "R6";
        drive(4'b0000, 2'b00, 13'h031);      // accepted
        drive(4'b0000, 2'b00, 13'h024);      // rejected, busy
        drive(4'b0000, 2'b10, 13'h062);      // rejected, busy
        check("R6 busy second cycle", int'(busy), 1);
        drive(4'b0000, 2'b10, 13'h022);      // accepted
        idle(1);
        check("R6 later write accepted", int'(drive_str), 1);
        check("R6 later write area", int'(refresh_area), 2);
        idle(3);

        cur_req = "R10";
        mrs(2'b00, 13'h02B);
        check("R10 error still set", int'(cfg_error), 1);

        cur_req = "R9";
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        check("R1 error cleared by reset", int'(cfg_error), 0);
        mrs(2'b01, 13'h033);
        check("R9 bank 01 rejected", int'(cfg_error), 1);
        check("R9 no valid", int'(cfg_valid), 0);
        mrs(2'b11, 13'h062);
        check("R9 bank 11 leaves drive", int'(drive_str), 1);
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule